// File: doc/BRIEF.md
# Reset Supervisor with Watchdog

This block produces the system reset for a chip region from three sources. The first is a supply-good flag from an external comparator. The second is a push-button style manual reset line. The third is a periodic strobe from the supervised processor.

Reset is held while the supply is bad or the button is pressed. When the last cause goes away, reset is stretched by a fixed number of clock cycles. A watchdog watches the strobe: any change of level counts as a sign of life. If the strobe stays still for too long, the watchdog fires one full-length reset pulse and starts counting again. The watchdog can be switched off with an enable input.

A build-time parameter chooses what a strobe change during reset does. In the latching variant it pins reset on until the module itself is reset, which stands for a power cycle. In the non-latching variant it has no effect on the release. Reset is driven on two outputs, one active-low and one active-high.

Top module: `rst_supervisor`

## Requirements
- R1: While `supply_ok` is 0, `sys_rst_n` is 0 in the same cycle, with no register in between.
- R2: After `supply_ok` returns to 1 with no other cause pending, `sys_rst_n` stays 0 for exactly HOLD_CYCLES rising clock edges and then goes to 1.
- R3: If `supply_ok` falls while the stretch is still running, reset stays asserted and the stretch count starts again from zero at the next recovery.
- R4: A 0 on `man_rst_n` asserts reset. After `man_rst_n` returns to 1, the same HOLD_CYCLES stretch applies.
- R5: A rising edge or a falling edge of `wd_strobe` restarts the watchdog count. A strobe that changes level more often than every WD_TIMEOUT cycles never causes a reset.
- R6: With the watchdog enabled and reset released, WD_TIMEOUT cycles with no strobe change assert reset for exactly HOLD_CYCLES cycles. The watchdog count is cleared while reset is asserted, so the next timeout comes WD_TIMEOUT cycles after the release.
- R7: While `wd_enable` is 0, the watchdog never asserts reset, whatever `wd_strobe` does.
- R8: With LATCH_ON_KICK=1, a strobe change seen while reset is asserted (and the watchdog is enabled) keeps reset asserted even after the supply is good. Only the module reset `rst` clears this state.
- R9: With LATCH_ON_KICK=0, strobe changes during reset do not stop reset from releasing after the normal stretch.
- R10: `sys_rst` is always the complement of `sys_rst_n`.
- R11: After the module reset `rst`, reset is asserted. With supply good and the button released, it releases HOLD_CYCLES cycles later.
- R12: `man_rst_n` and `wd_strobe` pass through a two-stage synchroniser. A button press takes effect on the third rising clock edge after it is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high module reset (power cycle); clears the latched state |
| supply_ok | input | 1 | 1 when the external comparator sees the supply above threshold |
| man_rst_n | input | 1 | Manual reset, active low, asynchronous to `clk` |
| wd_strobe | input | 1 | Watchdog strobe; either edge is a kick |
| wd_enable | input | 1 | 1 enables the watchdog |
| sys_rst_n | output | 1 | System reset, active low |
| sys_rst | output | 1 | System reset, active high |

## Verification
Two instances are built, one latching and one non-latching. Both get the same input patterns:
- supply dips that land inside and outside the stretch window, which separates a restarted stretch from a continued one;
- button presses;
- a strobe that keeps toggling, and a strobe that stops.

A stopped strobe is timed on both the low and the high phase. This shows both the pulse length and the re-arming of the watchdog. A press is sampled edge by edge to show the synchroniser depth. A strobe that toggles during a supply dip is where the two variants must differ: the latching instance stays in reset and the other releases. A final module reset shows that only `rst` clears the latch.

// File: rtl/rsup_pkg.sv
package rsup_pkg;

    // Asynchronous pins that must be synchronised before use.
    typedef struct packed {
        logic mr_n;
        logic strobe;
    } rsup_pins_t;

    // Width of a counter that must hold the values 0 .. n-1.
    function automatic int cnt_width(input int n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/rsup_sync.sv
module rsup_sync #(
    parameter int         W       = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // Two flops per bit.
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic meta;
        always_ff @(posedge clk) begin
            if (rst) begin
                meta <= RST_VAL[i];
                q[i] <= RST_VAL[i];
            end else begin
                meta <= d[i];
                q[i] <= meta;
            end
        end
    end
endmodule

// File: rtl/rsup_watchdog.sv
module rsup_watchdog #(
    parameter int TIMEOUT = 1024,
    parameter int W       = 10
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         enable,
    input  logic         strobe_s,
    input  logic         hold,
    output logic         kick,
    output logic         timeout,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] LAST = W'(TIMEOUT - 1);

    logic       prev;
    logic [1:0] settle;
    logic       armed;

    // Edges are ignored until the synchroniser has been refilled after rst.
    assign armed = (settle == 2'd3);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev   <= 1'b0;
            settle <= 2'd0;
        end else begin
            prev <= strobe_s;
            if (!armed) settle <= settle + 2'd1;
        end
    end

    assign kick    = armed & enable & (strobe_s ^ prev);
    assign timeout = enable & ~hold & ~kick & (count == LAST);

    always_ff @(posedge clk) begin
        if (rst || hold || !enable || kick || timeout) count <= '0;
        else                                           count <= count + W'(1);
    end
endmodule

// File: rtl/rsup_sequencer.sv
module rsup_sequencer #(
    parameter int TD    = 64,
    parameter int W     = 6,
    parameter bit LATCH = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         supply_ok,
    input  logic         mr_n_s,
    input  logic         wd_timeout,
    input  logic         kick,
    output logic         active,
    output logic         latched,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] LAST = W'(TD - 1);

    if (LATCH) begin : g_latch
        always_ff @(posedge clk) begin
            if (rst)                 latched <= 1'b0;
            else if (active && kick) latched <= 1'b1;
        end
    end else begin : g_nolatch
        assign latched = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b1;
            count  <= '0;
        end else if (!supply_ok || !mr_n_s || latched || wd_timeout) begin
            active <= 1'b1;
            count  <= '0;
        end else if (active) begin
            if (count == LAST) active <= 1'b0;
            else               count  <= count + W'(1);
        end
    end
endmodule

// File: rtl/rst_supervisor.sv
module rst_supervisor
    import rsup_pkg::*;
#(
    parameter int HOLD_CYCLES   = 64,
    parameter int WD_TIMEOUT    = 1024,
    parameter bit LATCH_ON_KICK = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic supply_ok,
    input  logic man_rst_n,
    input  logic wd_strobe,
    input  logic wd_enable,
    output logic sys_rst_n,
    output logic sys_rst
);
    localparam int HOLD_W = cnt_width(HOLD_CYCLES);
    localparam int WD_W   = cnt_width(WD_TIMEOUT);

    rsup_pins_t        raw_pins;
    rsup_pins_t        sync_pins;
    logic              hold_active;
    logic              latched;
    logic              wd_kick;
    logic              wd_timeout;
    logic [WD_W-1:0]   wd_count;
    logic [HOLD_W-1:0] hold_count;

    assign raw_pins.mr_n   = man_rst_n;
    assign raw_pins.strobe = wd_strobe;

    rsup_sync #(.W(2), .RST_VAL(2'b10)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_pins),
        .q   (sync_pins)
    );

    rsup_watchdog #(.TIMEOUT(WD_TIMEOUT), .W(WD_W)) u_wdog (
        .clk      (clk),
        .rst      (rst),
        .enable   (wd_enable),
        .strobe_s (sync_pins.strobe),
        .hold     (hold_active),
        .kick     (wd_kick),
        .timeout  (wd_timeout),
        .count    (wd_count)
    );

    rsup_sequencer #(.TD(HOLD_CYCLES), .W(HOLD_W), .LATCH(LATCH_ON_KICK)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .supply_ok  (supply_ok),
        .mr_n_s     (sync_pins.mr_n),
        .wd_timeout (wd_timeout),
        .kick       (wd_kick),
        .active     (hold_active),
        .latched    (latched),
        .count      (hold_count)
    );

    // A supply drop bypasses the registers so that reset follows it at once.
    assign sys_rst   = hold_active | ~supply_ok;
    assign sys_rst_n = ~sys_rst;
endmodule

// File: rtl/rsup_checker.sv
module rsup_checker #(
    parameter int TD     = 64,
    parameter int HOLD_W = 6,
    parameter int WD_W   = 10
) (
    input logic              clk,
    input logic              rst,
    input logic              supply_ok,
    input logic              wd_enable,
    input logic              sys_rst_n,
    input logic              sys_rst,
    input logic              hold_active,
    input logic              latched,
    input logic              wd_timeout,
    input logic [WD_W-1:0]   wd_count,
    input logic [HOLD_W-1:0] hold_count
);
    a_r1_supply_low: assert property (@(posedge clk) disable iff (rst)
        !supply_ok |-> !sys_rst_n);

    a_r10_complement: assert property (@(posedge clk) disable iff (rst)
        sys_rst != sys_rst_n);

    a_r2_release_needs_supply: assert property (@(posedge clk) disable iff (rst)
        $rose(sys_rst_n) |-> (supply_ok && $past(supply_ok)));

    a_r2_stretch_bound: assert property (@(posedge clk) disable iff (rst)
        hold_count <= HOLD_W'(TD - 1));

    a_r6_wd_cleared_in_reset: assert property (@(posedge clk) disable iff (rst)
        hold_active |=> (wd_count == '0));

    a_r6_timeout_restarts_hold: assert property (@(posedge clk) disable iff (rst)
        wd_timeout |=> (hold_active && hold_count == '0));

    a_r7_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
        !wd_enable |-> !wd_timeout);

    a_r8_latched_holds: assert property (@(posedge clk) disable iff (rst)
        latched |-> !sys_rst_n);
endmodule

bind rst_supervisor rsup_checker #(
    .TD     (HOLD_CYCLES),
    .HOLD_W (HOLD_W),
    .WD_W   (WD_W)
) chk (
    .clk         (clk),
    .rst         (rst),
    .supply_ok   (supply_ok),
    .wd_enable   (wd_enable),
    .sys_rst_n   (sys_rst_n),
    .sys_rst     (sys_rst),
    .hold_active (hold_active),
    .latched     (latched),
    .wd_timeout  (wd_timeout),
    .wd_count    (wd_count),
    .hold_count  (hold_count)
);

// File: tb/rst_supervisor_test.sv
module rst_supervisor_test;
    localparam int TD   = 8;
    localparam int TO   = 20;
    localparam int TOGP = 3;
    localparam int NV   = 11;

    // Vector fields: [15] supply_ok, [14] man_rst_n, [13] wd_enable,
    // [12] strobe toggling, [11:4] cycles to wait, [0] expected sys_rst_n.
    localparam logic [15:0] VEC [NV] = '{
        16'hC0C1,  // R11 power-on stretch ends
        16'h4010,  // R1 supply drop
        16'hC040,  // R2 inside stretch
        16'h4010,  // R3 drop during stretch
        16'hC060,  // R3 restarted stretch still low
        16'hC041,  // R3 released after full restart
        16'h8050,  // R4 button pressed
        16'hC050,  // R4 stretch after button
        16'hC081,  // R4 released
        16'hF641,  // R5 toggling strobe keeps reset off
        16'hC641   // R7 watchdog disabled
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic supply_ok = 1'b1;
    logic man_rst_n = 1'b1;
    logic wd_strobe = 1'b0;
    logic wd_enable = 1'b0;
    logic tog = 1'b0;
    logic rn_l, r_l, rn_n, r_n;

    int checks = 0;
    int fails  = 0;
    int n;
    bit done = 1'b0;

    always #5 clk = ~clk;

    rst_supervisor #(.HOLD_CYCLES(TD), .WD_TIMEOUT(TO), .LATCH_ON_KICK(1'b1)) uut (
        .clk(clk), .rst(rst), .supply_ok(supply_ok), .man_rst_n(man_rst_n),
        .wd_strobe(wd_strobe), .wd_enable(wd_enable), .sys_rst_n(rn_l), .sys_rst(r_l));

    rst_supervisor #(.HOLD_CYCLES(TD), .WD_TIMEOUT(TO), .LATCH_ON_KICK(1'b0)) uut_nl (
        .clk(clk), .rst(rst), .supply_ok(supply_ok), .man_rst_n(man_rst_n),
        .wd_strobe(wd_strobe), .wd_enable(wd_enable), .sys_rst_n(rn_n), .sys_rst(r_n));

    // Strobe generator: flips every TOGP cycles while tog is set, else parks at 0.
    initial begin
        int ph = 0;
        forever begin
            @(negedge clk);
            if (tog) begin
                ph++;
                if (ph >= TOGP) begin
                    wd_strobe = ~wd_strobe;
                    ph = 0;
                end
            end else begin
                wd_strobe = 1'b0;
                ph = 0;
            end
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cycles(input int k);
        for (int i = 0; i < k; i++) @(negedge clk);
    endtask

    // Counts consecutive samples of the latching instance at level val.
    task automatic count_level(input logic val, input int max, output int cnt);
        cnt = 0;
        while (rn_l === val && cnt < max) begin
            cnt++;
            @(negedge clk);
        end
    endtask

    initial begin
        cycles(3);
        rst = 1'b0;
        @(negedge clk);
        check("R11 reset state sys_rst_n", rn_l, 0);
        check("R10 reset state sys_rst", r_l, 1);
        check("R11 reset state non-latching", rn_n, 0);

        for (int v = 0; v < NV; v++) begin
            supply_ok = VEC[v][15];
            man_rst_n = VEC[v][14];
            wd_enable = VEC[v][13];
            tog       = VEC[v][12];
            cycles(int'(VEC[v][11:4]));
            check($sformatf("vector %0d latching (R1-R7 table)", v), rn_l, VEC[v][0]);
            check($sformatf("vector %0d non-latching", v), rn_n, VEC[v][0]);
            check("R10 complement", r_l, !rn_l);
        end

        // R12: the press shows after the third edge, not before.
        man_rst_n = 1'b0;
        cycles(2);
        check("R12 press after two edges", rn_l, 1);
        cycles(1);
        check("R12 press after three edges", rn_l, 0);
        man_rst_n = 1'b1;
        cycles(TD + 6);
        check("R4 release after press", rn_l, 1);

        // R2: exact stretch length after a supply dip.
        supply_ok = 1'b0;
        cycles(3);
        supply_ok = 1'b1;
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (rn_l == 1'b0 && n < 100);
        check("R2 stretch length", n, TD);

        // R6: a stopped strobe gives a TD pulse, then re-arms for TO cycles.
        wd_enable = 1'b1;
        n = 0;
        while (rn_l == 1'b1 && n < 100) begin
            @(negedge clk);
            n++;
        end
        check("R6 watchdog fired", rn_l, 0);
        count_level(1'b0, 100, n);
        check("R6 pulse length", n, TD);
        count_level(1'b1, 100, n);
        check("R6 re-armed timeout", n, TO);

        // R7: disabled watchdog stays quiet.
        wd_enable = 1'b0;
        cycles(TD + 3 * TO);
        check("R7 no timeout while disabled", rn_l, 1);

        // R8 / R9: strobe toggles during a supply dip.
        wd_enable = 1'b1;
        tog = 1'b1;
        supply_ok = 1'b0;
        cycles(12);
        supply_ok = 1'b1;
        cycles(TD + 12);
        check("R8 latching instance held", rn_l, 0);
        check("R9 non-latching instance released", rn_n, 1);
        cycles(40);
        check("R8 latch persists", rn_l, 0);
        check("R9 still fed", rn_n, 1);

        // R8: only module reset clears the latch.
        tog = 1'b0;
        wd_enable = 1'b0;
        rst = 1'b1;
        cycles(3);
        rst = 1'b0;
        @(negedge clk);
        check("R11 reset after rst", rn_l, 0);
        cycles(TD + 4);
        check("R8 latch cleared by rst", rn_l, 1);
        check("R10 complement at end", r_l, 0);

        done = 1'b1;
    end

    initial begin
        for (int i = 0; i < 20000 && !done; i++) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired actual=hung expected=done");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule